// File: doc/BRIEF.md
# Streaming Memory Write Channel

This block moves one logical write from a producer into memory over an AXI4 write port. A request gives a start address and a length in bytes. The producer then sends the words of that write over a valid/ready stream. The block stores the words in a small beat buffer. It cuts the transfer into INCR bursts that never cross a page, and it gives each burst the next AXI ID in turn. It counts the bursts whose write response has not yet come back.

The `flushed` output tells the user when the written data can be relied on. It stays low from the moment a request is taken until the last write response of that request has returned. The request side is held off until every word of the current write has been accepted and every burst has been sent. Start address and byte length must be multiples of the data width. A zero-length request is accepted and has no effect.

Top module: `axi_stream_writer`

## Requirements
- R1: While reset is held, `req_ready` and `flushed` are 1, and `m_awvalid`, `m_wvalid` and `dat_ready` are 0.
- R2: Each burst starts where the previous one ended. Its length in beats is the smallest of three values: the beats still to send, MAX_BEATS, and the beats left before the next PAGE_BYTES boundary. `m_awlen` is that length minus one, so no burst crosses a page.
- R3: The address channel holds its values stable until it is accepted. `m_wlast` is 1 on the final beat of each burst and on no other beat. `m_wvalid` is 0 in the cycle after a final beat is accepted.
- R4: Every beat has `m_wstrb` all ones. `m_awsize` equals log2(DATA_BYTES), and `m_awburst` is 2'b01 (incrementing).
- R5: Burst IDs run 0, 1, ..., ID_COUNT-1 and then wrap to 0. The sequence continues from one request to the next.
- R6: The count of bursts whose address has been accepted and whose write response has not returned never exceeds MAX_OUTSTANDING. An address handshake adds one to this count, and a response handshake removes one.
- R7: The address of a burst is offered only once all of that burst's words have been taken from the producer, so its data phase never waits on the producer.
- R8: `flushed` is 0 exactly while the current request still has words to accept, bursts to send, or write responses outstanding. Otherwise it is 1.
- R9: `req_ready` is 1 exactly when the previous request's words have all been accepted and all its bursts fully sent. Requests carry an address and a length that are multiples of DATA_BYTES, and a zero-length request completes at once.
- R10: `dat_ready` is 0 outside an active request. Exactly byte length / DATA_BYTES words are taken per request.
- R11: Word k of a request lands at start address + k*DATA_BYTES. The words just before and just after the target range are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a new request |
| req_addr | input | ADDR_W | Start byte address, aligned to DATA_BYTES |
| req_bytes | input | LEN_W | Transfer length in bytes, a multiple of DATA_BYTES |
| dat_valid | input | 1 | Producer word valid |
| dat_ready | output | 1 | Block takes the word this cycle |
| dat_word | input | DATA_BYTES*8 | Producer word |
| flushed | output | 1 | No work pending and no response outstanding |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Burst beats minus one |
| m_awsize | output | 3 | log2 of beat bytes |
| m_awburst | output | 2 | Burst type, always incrementing |
| m_awid | output | ID_W | Burst ID |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_BYTES*8 | Write data |
| m_wstrb | output | DATA_BYTES | Byte strobes, all ones |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready, always 1 |

## Verification
The bench uses small parameter values: 4-byte words, 64-byte pages, bursts of at most 4 beats, 3 IDs and at most 2 bursts outstanding. With these values a full sweep of every word offset inside a page, every length from 0 to 20 words, and several pages fits in a short run. The sweep reaches page splits at every position, bursts cut short by the tail of a request, ID wrap across requests, and stalls on the outstanding limit. The memory model accepts addresses and data in irregular patterns and delays responses. This holds `flushed` low across a long tail of pending responses, which the bench compares cycle by cycle against its own count.

// File: rtl/axw_pkg.sv
package axw_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/axw_beat_fifo.sv
module axw_beat_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wp, rp;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = store[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  p_push_room_r10: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_pop_data_r7:   assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/axw_burst_sizer.sv
module axw_burst_sizer #(
  parameter int CNT_W      = 29,
  parameter int OFF_W      = 9,
  parameter int PAGE_BEATS = 512,
  parameter int MAX_BEATS  = 16,
  parameter int BEAT_W     = 5
) (
  input  logic [OFF_W-1:0]  beat_off,
  input  logic [CNT_W-1:0]  beats_left,
  output logic [BEAT_W-1:0] beats
);
  logic [CNT_W-1:0] page_left, cap, take;

  assign page_left = CNT_W'(PAGE_BEATS) - CNT_W'(beat_off);

  generate
    if (MAX_BEATS >= PAGE_BEATS) begin : g_page_only
      assign cap = page_left;
    end else begin : g_both
      assign cap = (page_left < CNT_W'(MAX_BEATS)) ? page_left : CNT_W'(MAX_BEATS);
    end
  endgenerate

  assign take  = (beats_left < cap) ? beats_left : cap;
  assign beats = BEAT_W'(take);
endmodule

// File: rtl/axw_resp_tracker.sv
module axw_resp_tracker #(
  parameter int MAX_OUT  = 8,
  parameter int ID_COUNT = 4,
  parameter int ID_W     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic            aw_fire,
  input  logic            b_fire,
  output logic            room,
  output logic            idle,
  output logic [ID_W-1:0] next_id
);
  localparam int OC_W = $clog2(MAX_OUT+1);

  logic [OC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      next_id <= '0;
    end else begin
      case ({aw_fire, b_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (issue) next_id <= (next_id == ID_W'(ID_COUNT-1)) ? '0 : next_id + 1'b1;
    end
  end

  assign room = (cnt < OC_W'(MAX_OUT));
  assign idle = (cnt == '0);

  p_no_overflow_r6:  assert property (@(posedge clk) disable iff (rst) cnt <= OC_W'(MAX_OUT));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst) b_fire |-> cnt != '0);
  p_id_range_r5:     assert property (@(posedge clk) disable iff (rst) next_id <= ID_W'(ID_COUNT-1));
endmodule

// File: rtl/axi_stream_writer.sv
module axi_stream_writer
  import axw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int DATA_BYTES  = 8,
  parameter int PAGE_BYTES  = 4096,
  parameter int MAX_BEATS   = 16,
  parameter int ID_COUNT    = 4,
  parameter int MAX_OUT     = 8,
  parameter int ID_W        = width_of(ID_COUNT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LEN_W-1:0]          req_bytes,
  input  logic                      dat_valid,
  output logic                      dat_ready,
  input  logic [DATA_BYTES*8-1:0]   dat_word,
  output logic                      flushed,
  output logic                      m_awvalid,
  input  logic                      m_awready,
  output logic [ADDR_W-1:0]         m_awaddr,
  output logic [7:0]                m_awlen,
  output logic [2:0]                m_awsize,
  output logic [1:0]                m_awburst,
  output logic [ID_W-1:0]           m_awid,
  output logic                      m_wvalid,
  input  logic                      m_wready,
  output logic [DATA_BYTES*8-1:0]   m_wdata,
  output logic [DATA_BYTES-1:0]     m_wstrb,
  output logic                      m_wlast,
  input  logic                      m_bvalid,
  output logic                      m_bready
);
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int DB_SH      = $clog2(DATA_BYTES);
  localparam int PAGE_SH    = $clog2(PAGE_BYTES);
  localparam int PAGE_BEATS = PAGE_BYTES / DATA_BYTES;
  localparam int OFF_W      = PAGE_SH - DB_SH;
  localparam int CNT_W      = LEN_W - DB_SH;
  localparam int BEAT_W     = $clog2(MAX_BEATS + 1);

  // transaction state
  logic [CNT_W-1:0]  in_left, bt_left;
  logic [ADDR_W-1:0] nxt_addr;
  // burst state
  logic              aw_pend, w_act;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [7:0]        aw_len_q;
  logic [ID_W-1:0]   aw_id_q;
  logic [BEAT_W-1:0] w_left;

  logic              busy, req_fire, dat_fire, launch, aw_fire, w_fire, b_fire;
  logic              room, idle;
  logic [ID_W-1:0]   next_id;
  logic [BEAT_W-1:0] plan_beats, buf_cnt;
  logic              buf_full, buf_empty;

  assign busy      = (in_left != '0) || (bt_left != '0) || aw_pend || w_act;
  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign dat_ready = (in_left != '0) && !buf_full;
  assign dat_fire  = dat_valid && dat_ready;
  assign aw_fire   = aw_pend && m_awready;
  assign w_fire    = w_act && m_wready;
  assign b_fire    = m_bvalid && m_bready;
  assign launch    = (bt_left != '0) && !aw_pend && !w_act && room &&
                     (buf_cnt >= plan_beats);

  axw_beat_fifo #(.WIDTH(DATA_W), .DEPTH(MAX_BEATS)) u_buf (
    .clk(clk), .rst(rst), .push(dat_fire), .din(dat_word), .pop(w_fire),
    .dout(m_wdata), .count(buf_cnt), .full(buf_full), .empty(buf_empty)
  );

  axw_burst_sizer #(.CNT_W(CNT_W), .OFF_W(OFF_W), .PAGE_BEATS(PAGE_BEATS),
                    .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W)) u_size (
    .beat_off(nxt_addr[PAGE_SH-1:DB_SH]), .beats_left(bt_left), .beats(plan_beats)
  );

  axw_resp_tracker #(.MAX_OUT(MAX_OUT), .ID_COUNT(ID_COUNT), .ID_W(ID_W)) u_trk (
    .clk(clk), .rst(rst), .issue(launch), .aw_fire(aw_fire), .b_fire(b_fire),
    .room(room), .idle(idle), .next_id(next_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_left   <= '0;
      bt_left   <= '0;
      nxt_addr  <= '0;
      aw_pend   <= 1'b0;
      aw_addr_q <= '0;
      aw_len_q  <= '0;
      aw_id_q   <= '0;
      w_left    <= '0;
      w_act     <= 1'b0;
    end else begin
      if (req_fire) begin
        in_left  <= req_bytes[LEN_W-1:DB_SH];
        bt_left  <= req_bytes[LEN_W-1:DB_SH];
        nxt_addr <= req_addr;
      end else begin
        if (dat_fire) in_left <= in_left - 1'b1;
        if (launch) begin
          bt_left  <= bt_left - CNT_W'(plan_beats);
          nxt_addr <= nxt_addr + (ADDR_W'(plan_beats) << DB_SH);
        end
      end
      if (launch) begin
        aw_pend   <= 1'b1;
        aw_addr_q <= nxt_addr;
        aw_len_q  <= 8'(plan_beats - 1'b1);
        aw_id_q   <= next_id;
        w_left    <= plan_beats;
        w_act     <= 1'b1;
      end else begin
        if (aw_fire) aw_pend <= 1'b0;
        if (w_fire) begin
          w_left <= w_left - 1'b1;
          if (w_left == BEAT_W'(1)) w_act <= 1'b0;
        end
      end
    end
  end

  assign flushed   = !busy && idle;
  assign m_awvalid = aw_pend;
  assign m_awaddr  = aw_addr_q;
  assign m_awlen   = aw_len_q;
  assign m_awid    = aw_id_q;
  assign m_awsize  = 3'(DB_SH);
  assign m_awburst = BURST_INCR;
  assign m_wvalid  = w_act;
  assign m_wlast   = (w_left == BEAT_W'(1));
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;

  p_page_r2: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> (int'(m_awaddr[PAGE_SH-1:0]) + (int'(m_awlen) + 1) * DATA_BYTES) <= PAGE_BYTES);
  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> int'(m_awlen) < MAX_BEATS);
  p_aw_hold_r3: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen) && $stable(m_awid));
  p_wlast_gap_r3: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid);
  p_wdata_ready_r7: assert property (@(posedge clk) disable iff (rst)
    m_wvalid |-> !buf_empty);
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flushed |-> !m_awvalid && !m_wvalid);
  p_req_idle_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !dat_ready);
  p_align_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> req_addr[DB_SH-1:0] == '0 && req_bytes[DB_SH-1:0] == '0);
endmodule

// File: tb/sim_axi_stream_writer.sv
module sim_axi_stream_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0, req_bytes = '0;
  logic        dat_valid = 1'b0, dat_ready;
  logic [31:0] dat_word = '0;
  logic        flushed;
  logic        m_awvalid, m_awready = 1'b0;
  logic [15:0] m_awaddr;
  logic [7:0]  m_awlen;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic [1:0]  m_awid;
  logic        m_wvalid, m_wready = 1'b0;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_wlast;
  logic        m_bvalid = 1'b0, m_bready;

  always #4 clk = ~clk;

  axi_stream_writer #(.ADDR_W(16), .LEN_W(16), .DATA_BYTES(4), .PAGE_BYTES(64),
                      .MAX_BEATS(4), .ID_COUNT(3), .MAX_OUT(2)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_word(dat_word), .flushed(flushed),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awid(m_awid),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int go_cnt = 0, done_cnt = 0;
  int cfg_tx = 0, cfg_words = 0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] mem [256];

  // bench view of the current request
  int st = 0, tx = 0, total = 0, pushed = 0, wb = 0, ab = 0, outst = 0, id_ctr = 0;
  int exp_addr = 0, exp_left = 0;
  int qa [8]; int ql [8]; int qn = 0; int q_beat = 0;
  int bt [8]; int bn = 0;

  function automatic logic [31:0] gen(input int t, input int k);
    return {t[15:0], k[15:0]} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    int p0, eb, cap, idx;
    bit complete;
    cyc = cyc + 1;
    if (cyc <= 5) begin
      rst = 1'b1;
      if (cyc == 5) begin
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(flushed == 1'b1, "R1 flushed", flushed, 1);
        chk(m_awvalid == 1'b0 && m_wvalid == 1'b0, "R1 valids", {m_awvalid, m_wvalid}, 0);
        chk(dat_ready == 1'b0, "R1 dat_ready", dat_ready, 0);
      end
    end else begin
      rst = 1'b0;
      p0 = pushed;
      complete = (st == 0) || (pushed == total && wb == total && ab == total);
      chk(flushed == (complete && outst == 0), "R8 flushed", flushed, complete && outst == 0);
      chk(req_ready == complete, "R9 req_ready", req_ready, complete);
      chk(outst <= 2, "R6 outstanding", outst, 2);
      if (st == 0 || pushed == total) chk(dat_ready == 1'b0, "R10 dat_ready idle", dat_ready, 0);
      if (st != 0 && complete && outst == 0) begin
        done_cnt++;
        st = 0;
      end
      // request
      req_valid = 1'b0;
      if (st == 0 && go_cnt != done_cnt) begin
        req_valid = 1'b1; req_addr = cfg_addr; req_bytes = 16'(cfg_words * 4);
        tx = cfg_tx; total = cfg_words; pushed = 0; wb = 0; ab = 0;
        exp_addr = int'(cfg_addr); exp_left = cfg_words; st = 1;
      end else if (st == 1) st = 2;
      // producer
      dat_valid = 1'b0;
      if (st == 2 && pushed < total && ((cyc + pushed) % 5) != 2) begin
        dat_valid = 1'b1;
        dat_word = gen(tx, pushed);
        if (dat_ready) pushed++;
      end
      // address channel
      m_awready = (cyc % 3) != 1;
      if (m_awvalid && m_awready) begin
        cap = 16 - ((exp_addr % 64) / 4);
        eb = exp_left; if (eb > 4) eb = 4; if (eb > cap) eb = cap;
        chk(int'(m_awaddr) == exp_addr, "R2 awaddr", m_awaddr, exp_addr);
        chk(int'(m_awlen) == eb - 1, "R2 awlen", m_awlen, eb - 1);
        chk(int'(m_awid) == id_ctr % 3, "R5 awid", m_awid, id_ctr % 3);
        chk(m_awsize == 3'd2 && m_awburst == 2'b01, "R4 size/burst", {m_awsize, m_awburst}, 5'b01001);
        chk(p0 >= ab + eb, "R7 data buffered", p0, ab + eb);
        qa[qn] = int'(m_awaddr); ql[qn] = int'(m_awlen); qn++;
        outst++; ab += eb; id_ctr++;
        exp_addr += eb * 4; exp_left -= eb;
      end
      // data channel
      m_wready = (qn > 0) && ((cyc % 4) != 3);
      if (m_wvalid && m_wready) begin
        idx = (qa[0] / 4) + q_beat;
        mem[idx % 256] = m_wdata;
        chk(m_wstrb == 4'hF, "R4 wstrb", m_wstrb, 4'hF);
        chk(m_wlast == (q_beat == ql[0]), "R3 wlast", m_wlast, q_beat == ql[0]);
        wb++; q_beat++;
        if (q_beat > ql[0]) begin
          for (int i = 0; i < 7; i++) begin qa[i] = qa[i+1]; ql[i] = ql[i+1]; end
          qn--; q_beat = 0;
          bt[bn] = cyc + 3 + (id_ctr % 4) * 2; bn++;
        end
      end
      // response channel
      m_bvalid = (bn > 0) && (cyc >= bt[0]);
      if (m_bvalid) begin
        for (int i = 0; i < 7; i++) bt[i] = bt[i+1];
        bn--; outst--;
      end
    end
  end

  initial begin
    int base, words;
    while (cyc < 8) @(posedge clk);
    for (int t = 0; t < 336; t++) begin
      @(posedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
      words = (t / 16) % 21;
      cfg_addr = 16'(16'h0100 + ((t / 3) % 4) * 64 + (t % 16) * 4);
      cfg_words = words; cfg_tx = t;
      go_cnt++;
      while (done_cnt != go_cnt) @(posedge clk);
      base = int'(cfg_addr) / 4;
      for (int k = 0; k < words; k++)
        chk(mem[base + k] == gen(t, k), "R11 memory word", mem[base + k], gen(t, k));
      chk(mem[base - 1] == 32'hDEAD_BEEF, "R11 below range", mem[base - 1], 32'hDEAD_BEEF);
      chk(mem[base + words] == 32'hDEAD_BEEF, "R11 above range", mem[base + words], 32'hDEAD_BEEF);
      chk(pushed == words, "R10 words taken", pushed, words);
    end
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 336);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule